// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits next to a free-running timer counter and takes the counter value as an input. When a chosen edge appears on the selected trigger, it copies that value into a capture register, sets a capture flag and, if enabled, raises an interrupt request. Software reads the register to timestamp events. It can measure a period by capturing one polarity, or a duty cycle by changing the polarity after each capture.

The trigger is either an external pin or an internal comparator output, picked by a select input. Each trigger input first passes a two-flop synchronizer. After the source mux there is an optional four-sample noise filter, clocked by the system clock, and then an edge detector. The filter only accepts a new level once four consecutive samples agree. This adds four clocks of latency.

A mode input marks the capture register as the timer's TOP value. In that mode edge events are ignored and the register can be loaded through a write port.

Every interface here is plain control and status. The captured value is a held register, not a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset `cap_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: With `src_sel_i`=0 the trigger is `pin_i`; with `src_sel_i`=1 it is `cmp_i`. The unselected input never causes a capture.
- R3: With `edge_rise_i`=1 only a 0-to-1 trigger transition captures; with `edge_rise_i`=0 only a 1-to-0 transition captures.
- R4: With the filter off, a trigger change applied before clock edge 1 shows its capture on `cap_o` and `flag_o` after clock edge 3, and not after edge 2.
- R5: With the filter on, the filtered level changes only after four consecutive equal samples. A trigger pulse of three clocks or fewer causes no capture.
- R6: With the filter on, the capture shows after clock edge 7, exactly four clocks later than in R4.
- R7: Each capture loads `cnt_i` (as sampled on the capture edge) into `cap_o` and sets `flag_o`. A newer capture overwrites an unread value.
- R8: A one-cycle pulse on `flag_clr_i` (write-one-to-clear) or on `irq_ack_i` clears `flag_o` at the next clock edge.
- R9: If a capture and a flag clear happen on the same edge, the flag stays set and `cap_o` takes the new count.
- R10: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R11: While `top_mode_i`=1, no capture happens and `wr_en_i` loads `wr_data_i` into `cap_o`. While `top_mode_i`=0, `wr_en_i` has no effect.
- R12: Changing `src_sel_i` between inputs at different levels produces a trigger transition. It captures if that transition matches the selected polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Timer counter value |
| pin_i | input | 1 | External trigger pin |
| cmp_i | input | 1 | Comparator output trigger |
| src_sel_i | input | 1 | 0 selects pin, 1 selects comparator |
| filt_en_i | input | 1 | Noise filter enable |
| edge_rise_i | input | 1 | 1 selects rising edge, 0 falling |
| top_mode_i | input | 1 | Capture register serves as timer TOP |
| wr_en_i | input | 1 | Write strobe for capture register (TOP mode) |
| wr_data_i | input | CNT_W | Write data for capture register |
| flag_clr_i | input | 1 | Write-one-to-clear for capture flag |
| irq_en_i | input | 1 | Capture interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| cap_o | output | CNT_W | Capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong stage count in the synchronizer or filter appears as a capture one clock early or late. The bench catches it by sampling the flag on the edge before and the edge after the expected one. A stuck or wrongly reset filter history either lets a short glitch through as a capture or swallows a genuine edge. Either result is visible on `flag_o` within seven clocks of the input change. A faulty edge-detector history or flag priority shows up on the first transition of the wrong polarity or the first clear/capture collision, as a changed `cap_o` or a dropped flag.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FILT_DEPTH  = 4;
  localparam int unsigned N_SRC       = 2;
  typedef enum logic {SRC_PIN = 1'b0, SRC_CMP = 1'b1} src_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic en_i,
  output logic lvl_o
);
  localparam int unsigned HW = DEPTH - 1;
  logic [HW-1:0] hist;
  logic          held;
  logic [DEPTH-1:0] window;
  logic all_hi, all_lo;

  assign window = {hist, raw_i};
  assign all_hi = &window;
  assign all_lo = ~|window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      held <= 1'b0;
    end else begin
      hist <= window[HW-1:0];
      if (all_hi)      held <= 1'b1;
      else if (all_lo) held <= 1'b0;
    end
  end

  assign lvl_o = en_i ? held : raw_i;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && !all_lo) |=> $stable(held)); // R5
endmodule

// File: rtl/icu_edge.sv
module icu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic arm_i,
  output logic evt_o
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_i;
  end
  assign evt_o = arm_i && (lvl_i != prev) && (lvl_i == rise_i);

  AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> (prev == rise_i)); // R3
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import icu_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             cmp_i,
  input  logic             src_sel_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             top_mode_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] sync_q;
  logic trig_raw, trig_lvl, cap_evt;

  icu_sync #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cmp_i, pin_i}), .q_o(sync_q));

  assign trig_raw = (src_e'(src_sel_i) == SRC_CMP) ? sync_q[1] : sync_q[0];

  icu_filter #(.DEPTH(FILT_DEPTH)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(trig_raw), .en_i(filt_en_i), .lvl_o(trig_lvl));

  icu_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(trig_lvl), .rise_i(edge_rise_i),
    .arm_i(!top_mode_i), .evt_o(cap_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (cap_evt)                     cap_o <= cnt_i;
      else if (top_mode_i && wr_en_i)  cap_o <= wr_data_i;
      if (cap_evt)                     flag_o <= 1'b1;
      else if (flag_clr_i || irq_ack_i) flag_o <= 1'b0;
    end
  end

  assign irq_o = flag_o & irq_en_i;

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_o); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr_i || irq_ack_i) && !cap_evt) |=> !flag_o); // R8
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !(top_mode_i && wr_en_i)) |=> $stable(cap_o)); // R11
  AST_TOP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode_i |-> !cap_evt); // R11
  AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_o == $past(cnt_i))); // R7
endmodule

// File: tb/tmr_capture_unit_bench.sv
module tmr_capture_unit_bench;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt = '0, wr_data = '0;
  logic pin = 0, cmp = 0, sel = 0, filt = 0, rise = 1, top = 0, wr_en = 0;
  logic clr = 0, irq_en = 0, ack = 0;
  logic [W-1:0] cap;
  logic flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  tmr_capture_unit #(.CNT_W(W)) u_tmr_capture_unit (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin), .cmp_i(cmp),
    .src_sel_i(sel), .filt_en_i(filt), .edge_rise_i(rise), .top_mode_i(top),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .flag_clr_i(clr), .irq_en_i(irq_en),
    .irq_ack_i(ack), .cap_o(cap), .flag_o(flag), .irq_o(irq));

  // {sel, rise, filt, pin, cmp, cnt, exp_cap, exp_flag}
  localparam logic [37:0] VEC [8] = '{
    {5'b01010, 16'd100, 16'd100, 1'b1},  // R2 R3 pin rise captured
    {5'b01000, 16'd200, 16'd100, 1'b0},  // R3 fall ignored with rise
    {5'b00010, 16'd300, 16'd100, 1'b0},  // R3 rise ignored with fall
    {5'b00000, 16'd400, 16'd400, 1'b1},  // R3 fall captured
    {5'b11001, 16'd500, 16'd500, 1'b1},  // R2 comparator rise
    {5'b11011, 16'd600, 16'd500, 1'b0},  // R2 pin ignored when comparator selected
    {5'b10110, 16'd700, 16'd700, 1'b1},  // R5 filtered fall captured
    {5'b01110, 16'd800, 16'd800, 1'b1}   // R2 filtered pin rise
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    clr = 1; tick(1); clr = 0; tick(1);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 cap", cap, 0); chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);
    rst_n = 1; tick(2);

    for (int i = 0; i < 8; i++) begin
      {sel, rise, filt, pin, cmp, cnt} = VEC[i][37:17];
      tick(10);
      chk($sformatf("R7 vec%0d cap", i), cap, VEC[i][16:1]);
      chk($sformatf("R7 vec%0d flag", i), flag, VEC[i][0]);
      clear_flag();
      chk("R8 clr", flag, 0);
    end

    // R4 latency, filter off, falling edge
    filt = 0; rise = 0; tick(8); clear_flag();
    pin = 0; cnt = 1111; tick(2);
    chk("R4 early", flag, 0);
    tick(1);
    chk("R4 flag", flag, 1); chk("R4 cap", cap, 1111);
    clear_flag(); tick(6);

    // R6 latency, filter on, rising edge
    filt = 1; rise = 1; pin = 1; cnt = 2222; tick(6);
    chk("R6 early", flag, 0);
    tick(1);
    chk("R6 flag", flag, 1); chk("R6 cap", cap, 2222);
    clear_flag();

    // R5 three-cycle low glitch with falling polarity
    rise = 0; tick(4);
    pin = 0; tick(3); pin = 1; tick(12);
    chk("R5 glitch flag", flag, 0); chk("R5 glitch cap", cap, 2222);

    // R7 overwrite
    filt = 0; rise = 1; pin = 0; tick(4);
    pin = 1; cnt = 3333; tick(4);
    chk("R7 first", cap, 3333);
    pin = 0; tick(3); pin = 1; cnt = 4444; tick(4);
    chk("R7 overwrite", cap, 4444); chk("R7 flag", flag, 1);

    // R10 and acknowledge
    irq_en = 1; tick(1); chk("R10 irq on", irq, 1);
    irq_en = 0; tick(1); chk("R10 irq masked", irq, 0);
    irq_en = 1; ack = 1; tick(1); ack = 0;
    chk("R8 ack", flag, 0); chk("R10 irq off", irq, 0);
    irq_en = 0;

    // R9 clear and capture on the same edge
    pin = 0; tick(4); pin = 1; cnt = 5555; tick(4);
    pin = 0; tick(4);
    pin = 1; cnt = 6666; tick(2);
    clr = 1; tick(1); clr = 0;
    chk("R9 flag", flag, 1); chk("R9 cap", cap, 6666);
    clear_flag();

    // R11 TOP mode
    top = 1; pin = 0; tick(4); pin = 1; cnt = 7777; tick(4);
    chk("R11 no cap", cap, 6666); chk("R11 no flag", flag, 0);
    wr_data = 16'hABCD; wr_en = 1; tick(1); wr_en = 0;
    chk("R11 write", cap, 16'hABCD);
    top = 0; tick(2);
    wr_data = 16'h1234; wr_en = 1; tick(1); wr_en = 0; tick(1);
    chk("R11 write ignored", cap, 16'hABCD); chk("R11 flag", flag, 0);

    // R12 source switch: pin=1, cmp=0, falling polarity
    rise = 0; cnt = 8888; sel = 1; tick(4);
    chk("R12 flag", flag, 1); chk("R12 cap", cap, 8888);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule